// File: doc/BRIEF.md
# Multi-Cycle 8-bit Accumulator Processor

This block is a small processor built around one 8-bit working register, the accumulator, plus an 8-bit program counter and an 8-bit ALU. Instructions are 16-bit words. The high byte selects the operation and the low byte carries an 8-bit operand address. A single memory port serves both instruction fetch and operand reads. An address-source select chooses the program counter during fetch and the operand field during operand reads. The memory returns two consecutive bytes in one read, so a whole instruction word reaches the instruction register in one cycle.

A control state machine advances one step per clock. Every instruction starts with a fetch step and a decode step. Execution then takes between zero and three further steps. All arithmetic goes through the shared ALU. The fetch step adds two to the program counter. Clearing is an AND with zero. The shift by three is three passes of accumulator plus accumulator. An integrating design attaches a memory to the address and read-data ports. It can observe the accumulator and the program counter, and it sees a flag that marks the first step of every instruction.

Top module: `acc8_core`

## Requirements
- R1: While reset is low and in the first cycle after it is released, `pc_o` and `acc_o` are 0 and `fetch_o` is 1.
- R2: In a fetch step, `mem_rd` is 1 and `mem_addr` equals `pc_o`. The word read has the opcode in bits 15:8 and the operand address in bits 7:0. In the next cycle `pc_o` is the old value plus 2, and `fetch_o` is 0.
- R3: Opcode 0x00 (clear) sets the accumulator to 0. The next fetch step comes 3 cycles after the fetch.
- R4: Opcode 0x01 (load) sets the accumulator to the memory byte at the operand address. That byte arrives on `mem_rdata[15:8]`. The next fetch comes 4 cycles after the fetch.
- R5: Opcode 0x02 (indirect jump) sets the program counter to the memory byte at the operand address and leaves the accumulator unchanged. The next fetch comes 4 cycles after the fetch.
- R6: Opcode 0x03 (shift by three) replaces the accumulator with its value shifted left by three places, keeping the low 8 bits. The next fetch comes 5 cycles after the fetch.
- R7: Any opcode above 0x03 changes nothing except the program counter step of R2. The next fetch comes 2 cycles after the fetch.
- R8: `mem_rd` is 1 only in fetch steps and in the operand-read step of load and indirect jump. During the operand read, `mem_addr` equals the operand field.
- R9: The program counter wraps modulo 256. An instruction at 0xFE is followed by the one at 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 8 | Byte address of the shared memory port |
| mem_rd | output | 1 | Memory read strobe |
| mem_rdata | input | 16 | Bytes at mem_addr (bits 15:8) and at mem_addr+1 (bits 7:0) |
| pc_o | output | 8 | Program counter |
| acc_o | output | 8 | Accumulator |
| fetch_o | output | 1 | High during the fetch step of each instruction |

## Verification
Each instruction has a fixed length, counted in cycles from its fetch step to the next fetch step: 3 for clear, 4 for load and indirect jump, 5 for shift by three, and 2 for an unknown opcode. The bench model counts these cycles down and compares the outputs on every falling edge. At each expected fetch step it compares `fetch_o`, `pc_o`, `acc_o` and the fetch address. In every other cycle it requires `fetch_o` low and `pc_o` already advanced by 2, because that increment is registered at the first edge after the fetch. Results are compared only at the following fetch step, since every accumulator or program-counter write lands on the edge that enters that step.

// File: rtl/acc8_pkg.sv
package acc8_pkg;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_CLEAR,
        ST_OPRD,
        ST_LDWB,
        ST_JPWB,
        ST_SHIFT
    } step_e;

    typedef enum logic [0:0] { PCS_ALU, PCS_MDR } pcsrc_e;
    typedef enum logic [0:0] { ALU_ADD, ALU_AND } aluop_e;
    typedef enum logic [0:0] { SA_PC, SA_ACC } srca_e;
    typedef enum logic [1:0] { SB_TWO, SB_ZERO, SB_ACC } srcb_e;
    typedef enum logic [0:0] { WD_ALU, WD_MDR } wsel_e;

    typedef struct packed {
        logic   mem_rd;
        logic   iord;
        logic   ir_we;
        logic   mdr_we;
        logic   pc_we;
        pcsrc_e pc_src;
        aluop_e alu_op;
        srca_e  src_a;
        srcb_e  src_b;
        logic   acc_we;
        wsel_e  acc_src;
    } ctrl_t;

    localparam logic [7:0] OP_CLEAR = 8'h00;
    localparam logic [7:0] OP_LOAD  = 8'h01;
    localparam logic [7:0] OP_JPTR  = 8'h02;
    localparam logic [7:0] OP_SHL3  = 8'h03;

endpackage

// File: rtl/acc8_ctrl.sv
module acc8_ctrl
    import acc8_pkg::*;
#(
    parameter int DW           = 8,
    parameter int SHIFT_PASSES = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] opcode,
    output ctrl_t         ctl,
    output logic          fetch
);
    localparam int CW = (SHIFT_PASSES < 2) ? 1 : $clog2(SHIFT_PASSES);
    localparam logic [CW-1:0] LAST = CW'(SHIFT_PASSES - 1);

    typedef struct packed {
        step_e         step;
        logic [CW-1:0] cnt;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        ctl   = '0;
        case (fsm_q.step)
            ST_FETCH: begin
                // read instruction word, PC <- PC + 2 through the ALU
                ctl.mem_rd = 1'b1;
                ctl.iord   = 1'b0;
                ctl.ir_we  = 1'b1;
                ctl.pc_we  = 1'b1;
                ctl.pc_src = PCS_ALU;
                ctl.alu_op = ALU_ADD;
                ctl.src_a  = SA_PC;
                ctl.src_b  = SB_TWO;
                fsm_d.step = ST_DECODE;
            end
            ST_DECODE: begin
                fsm_d.cnt = '0;
                if (opcode == DW'(OP_CLEAR))
                    fsm_d.step = ST_CLEAR;
                else if (opcode == DW'(OP_LOAD) || opcode == DW'(OP_JPTR))
                    fsm_d.step = ST_OPRD;
                else if (opcode == DW'(OP_SHL3))
                    fsm_d.step = ST_SHIFT;
                else
                    fsm_d.step = ST_FETCH;
            end
            ST_CLEAR: begin
                // A <- A AND 0
                ctl.acc_we  = 1'b1;
                ctl.acc_src = WD_ALU;
                ctl.alu_op  = ALU_AND;
                ctl.src_a   = SA_ACC;
                ctl.src_b   = SB_ZERO;
                fsm_d.step  = ST_FETCH;
            end
            ST_OPRD: begin
                ctl.mem_rd = 1'b1;
                ctl.iord   = 1'b1;
                ctl.mdr_we = 1'b1;
                fsm_d.step = (opcode == DW'(OP_JPTR)) ? ST_JPWB : ST_LDWB;
            end
            ST_LDWB: begin
                ctl.acc_we  = 1'b1;
                ctl.acc_src = WD_MDR;
                fsm_d.step  = ST_FETCH;
            end
            ST_JPWB: begin
                ctl.pc_we  = 1'b1;
                ctl.pc_src = PCS_MDR;
                fsm_d.step = ST_FETCH;
            end
            ST_SHIFT: begin
                // A <- A + A, repeated SHIFT_PASSES times
                ctl.acc_we  = 1'b1;
                ctl.acc_src = WD_ALU;
                ctl.alu_op  = ALU_ADD;
                ctl.src_a   = SA_ACC;
                ctl.src_b   = SB_ACC;
                fsm_d.cnt   = fsm_q.cnt + 1'b1;
                if (fsm_q.cnt == LAST)
                    fsm_d.step = ST_FETCH;
            end
            default: fsm_d.step = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q.step <= ST_FETCH;
            fsm_q.cnt  <= '0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign fetch = (fsm_q.step == ST_FETCH);

endmodule

// File: rtl/acc8_alu.sv
module acc8_alu
    import acc8_pkg::*;
#(
    parameter int DW = 8
) (
    input  aluop_e        op,
    input  srca_e         src_a,
    input  srcb_e         src_b,
    input  logic [DW-1:0] pc,
    input  logic [DW-1:0] acc,
    output logic [DW-1:0] y
);
    logic [DW-1:0] a, b;

    always_comb begin
        a = (src_a == SA_PC) ? pc : acc;
        case (src_b)
            SB_TWO:  b = DW'(2);
            SB_ACC:  b = acc;
            default: b = '0;
        endcase
        case (op)
            ALU_AND: y = a & b;
            default: y = a + b;
        endcase
    end

endmodule

// File: rtl/acc8_regs.sv
module acc8_regs
    import acc8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  ctrl_t           ctl,
    input  logic [DW-1:0]   alu_y,
    input  logic [2*DW-1:0] mem_rdata,
    output logic [DW-1:0]   pc,
    output logic [DW-1:0]   acc,
    output logic [2*DW-1:0] ir,
    output logic [DW-1:0]   mdr
);
    localparam int IW = 2 * DW;

    typedef struct packed {
        logic [IW-1:0] ir;
        logic [DW-1:0] mdr;
        logic [DW-1:0] pc;
        logic [DW-1:0] acc;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (ctl.ir_we)
            r_d.ir = mem_rdata;
        if (ctl.mdr_we)
            r_d.mdr = mem_rdata[IW-1 -: DW];
        if (ctl.pc_we)
            r_d.pc = (ctl.pc_src == PCS_MDR) ? r_q.mdr : alu_y;
        if (ctl.acc_we)
            r_d.acc = (ctl.acc_src == WD_MDR) ? r_q.mdr : alu_y;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            r_q <= '0;
        else
            r_q <= r_d;
    end

    assign pc  = r_q.pc;
    assign acc = r_q.acc;
    assign ir  = r_q.ir;
    assign mdr = r_q.mdr;

endmodule

// File: rtl/acc8_core.sv
module acc8_core
    import acc8_pkg::*;
#(
    parameter int DW           = 8,
    parameter int SHIFT_PASSES = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [DW-1:0]   mem_addr,
    output logic            mem_rd,
    input  logic [2*DW-1:0] mem_rdata,
    output logic [DW-1:0]   pc_o,
    output logic [DW-1:0]   acc_o,
    output logic            fetch_o
);
    localparam int IW = 2 * DW;

    ctrl_t         ctl;
    logic [DW-1:0] alu_y;
    logic [DW-1:0] pc, acc, mdr;
    logic [IW-1:0] ir;

    acc8_ctrl #(.DW(DW), .SHIFT_PASSES(SHIFT_PASSES)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .opcode (ir[IW-1:DW]),
        .ctl    (ctl),
        .fetch  (fetch_o)
    );

    acc8_alu #(.DW(DW)) u_alu (
        .op    (ctl.alu_op),
        .src_a (ctl.src_a),
        .src_b (ctl.src_b),
        .pc    (pc),
        .acc   (acc),
        .y     (alu_y)
    );

    acc8_regs #(.DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .alu_y     (alu_y),
        .mem_rdata (mem_rdata),
        .pc        (pc),
        .acc       (acc),
        .ir        (ir),
        .mdr       (mdr)
    );

    assign mem_addr = ctl.iord ? ir[DW-1:0] : pc;
    assign mem_rd   = ctl.mem_rd;
    assign pc_o     = pc;
    assign acc_o    = acc;

endmodule

// File: rtl/acc8_core_chk.sv
module acc8_core_chk #(
    parameter int DW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [DW-1:0]   mem_addr,
    input logic            mem_rd,
    input logic [2*DW-1:0] mem_rdata,
    input logic [DW-1:0]   pc_o,
    input logic [DW-1:0]   acc_o,
    input logic            fetch_o
);
    logic [DW-1:0] op;
    assign op = mem_rdata[2*DW-1:DW];

    assert_fetch_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_o |-> (mem_rd && mem_addr == pc_o));

    assert_pc_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_o |=> (!fetch_o && pc_o == DW'($past(pc_o) + DW'(2))));

    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_o && op == DW'(0)) |=> ##2 (fetch_o && acc_o == '0));

    assert_load_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_o && op == DW'(1)) |=> ##3 fetch_o);

    assert_jptr_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_o && op == DW'(2)) |=> ##3 (fetch_o && acc_o == $past(acc_o, 4)));

    assert_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_o && op == DW'(3)) |=> ##4 (fetch_o && acc_o == DW'($past(acc_o, 5) << 3)));

    assert_bad_op_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_o && op > DW'(3)) |=> ##1 (fetch_o && acc_o == $past(acc_o, 2)));

    assert_rd_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_o && op > DW'(0) && op < DW'(3)) |=> ##1 mem_rd);

endmodule

bind acc8_core acc8_core_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_rdata (mem_rdata),
    .pc_o      (pc_o),
    .acc_o     (acc_o),
    .fetch_o   (fetch_o)
);

// File: tb/sim_acc8_core.sv
`timescale 1ns/1ps
module sim_acc8_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  mem_addr;
    logic        mem_rd;
    logic [15:0] mem_rdata;
    logic [7:0]  pc_o, acc_o;
    logic        fetch_o;
    logic [7:0]  mem [256];

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    assign mem_rdata = {mem[mem_addr], mem[mem_addr + 8'd1]};

    acc8_core u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_rdata (mem_rdata),
        .pc_o      (pc_o),
        .acc_o     (acc_o),
        .fetch_o   (fetch_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] a, input logic [7:0] op, input logic [7:0] arg);
        mem[a]        = op;
        mem[a + 8'd1] = arg;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        put(8'h00, 8'h01, 8'h80);   // load      -> 15
        put(8'h02, 8'h03, 8'h00);   // shift     -> a8
        put(8'h04, 8'h03, 8'h00);   // shift     -> 40
        put(8'h06, 8'h7f, 8'h55);   // unknown
        put(8'h08, 8'h00, 8'h00);   // clear
        put(8'h0a, 8'h01, 8'h81);   // load      -> ff
        put(8'h0c, 8'h03, 8'h00);   // shift     -> f8
        put(8'h0e, 8'h02, 8'h82);   // jump      -> 20
        put(8'h20, 8'h01, 8'h83);   // load      -> 01
        put(8'h22, 8'h03, 8'h00);   // shift     -> 08
        put(8'h24, 8'h02, 8'h84);   // jump      -> fe
        put(8'hfe, 8'h00, 8'h00);   // clear, then pc wraps to 00
        mem[8'h80] = 8'h15;
        mem[8'h81] = 8'hff;
        mem[8'h82] = 8'h20;
        mem[8'h83] = 8'h01;
        mem[8'h84] = 8'hfe;
    end

    initial begin
        logic [7:0] exp_pc, exp_acc, mid_pc, op, arg;
        int rem;
        string tag;
        rst_n = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check(pc_o == 8'h00,  "R1", "reset pc",    pc_o,    0);
            check(acc_o == 8'h00, "R1", "reset acc",   acc_o,   0);
            check(fetch_o == 1'b1, "R1", "reset fetch", fetch_o, 1);
        end
        rst_n   = 1'b1;
        exp_pc  = 8'h00;
        exp_acc = 8'h00;
        mid_pc  = 8'h00;
        rem     = 0;
        tag     = "R1";
        for (int c = 0; c < 600; c++) begin
            if (rem == 0) begin
                check(fetch_o == 1'b1, tag, "fetch step due", fetch_o, 1);
                check(pc_o == exp_pc, tag, "pc at fetch", pc_o, exp_pc);
                check(acc_o == exp_acc, tag, "acc at fetch", acc_o, exp_acc);
                check(mem_rd && mem_addr == pc_o, "R8", "fetch address", mem_addr, pc_o);
                op     = mem[exp_pc];
                arg    = mem[exp_pc + 8'd1];
                mid_pc = exp_pc + 8'd2;
                exp_pc = mid_pc;
                case (op)
                    8'h00: begin exp_acc = 8'h00;         rem = 2; tag = "R3"; end
                    8'h01: begin exp_acc = mem[arg];      rem = 3; tag = "R4"; end
                    8'h02: begin exp_pc  = mem[arg];      rem = 3; tag = "R5"; end
                    8'h03: begin exp_acc = exp_acc << 3;  rem = 4; tag = "R6"; end
                    default: begin                         rem = 1; tag = "R7"; end
                endcase
                if (mid_pc == 8'h00) tag = "R9";
            end else begin
                check(fetch_o == 1'b0, tag, "no fetch mid-instruction", fetch_o, 0);
                check(pc_o == mid_pc, "R2", "pc advanced by 2", pc_o, mid_pc);
                rem--;
            end
            @(negedge clk);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule